// File: doc/BRIEF.md
# Fractional-Rate 64-bit Timestamp Clock

This block keeps a 64-bit time-of-day count for precision time protocol hardware, running from a 100 MHz reference clock. The count does not simply tick once per reference cycle. A 32-bit rate word is added into a 32-bit phase accumulator on every cycle, and each carry out of that addition advances the count by one. The nominal counting frequency is therefore (rate word / 2^32) x 100 MHz. For example, 80000000h gives 50 MHz, C0000000h gives 75 MHz and E6666666h gives 90 MHz. Servo software trims the rate word to steer the clock without stepping it.

A small synchronous register port in the same clock domain serves the host. To read the 64-bit time coherently, the host first writes a capture command; both 32-bit halves then read back from a frozen copy. To set the time, the host writes both halves in either order, and the count takes the new value only once both have arrived. The live count is also presented on a 64-bit output, the single time source for every other precision-time function on the chip.

Top module: `frac_time_clock`

## Requirements
- R1: After reset, the accumulator, count, capture registers and pending-load flags are zero, and the rate word reads 80000000h.
- R2: On every cycle, the rate word is added into the accumulator modulo 2^32, and the remainder is kept. The count advances by exactly one in each cycle where that addition carries out of bit 31, and by no more than one per cycle.
- R3: The count rate follows the rate word. With 80000000h the count advances once every 2 cycles; with C0000000h it advances 3 times every 4 cycles, counted from a cleared accumulator.
- R4: A write to the rate word (address 1) is used from the next cycle's addition onward. The count and the accumulator are not disturbed by the write.
- R5: Writing address 0 with bit 0 set captures the count value present before that clock edge. Reads of address 2 (bits 63:32) and address 3 (bits 31:0) return the captured value, even if the low word of the live count rolls over between the two reads.
- R6: After a capture command, the command bit at address 0, bit 0, reads 1 for one cycle and then clears by itself. The captured value stays unchanged until the next capture command.
- R7: A time load needs a write to address 2 (high half) and a write to address 3 (low half), in either order. A single half on its own leaves the count untouched.
- R8: In the cycle after the second half is written, the count takes the loaded value and the accumulator clears. Any carry due in that cycle is dropped, and both pending flags clear.
- R9: The rate word reads back at address 1. A write to address 0 with bit 0 clear has no effect, and address 0 reads zero outside the one-cycle command pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 100 MHz reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 2 | Register select: 0 command, 1 rate word, 2 time high, 3 time low |
| host_wr | input | 1 | Write strobe for the selected register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for the selected register (combinational from host_addr) |
| time_now | output | 64 | Live 64-bit count |

## Verification
The bench builds the block with its default parameters: a 32-bit accumulator and rate word, 32-bit host words and a 64-bit count. With these values the edge cases fall within a few cycles. A rate word of FFFFFFFFh gives a carry on almost every cycle. A load just below 2^32 forces the low-word rollover between captures. A zero rate word freezes the count so that loads can be read back exactly. Directed rate checks over hundreds of cycles and a long stretch of random register traffic are compared against a behavioural model on every clock.

// File: rtl/ftc_pkg.sv
// Package: shared register map for the fractional-rate timestamp clock.
// Assumes a 2-bit host address space with four word registers.
package ftc_pkg;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CMD    = 2'd0,
        REG_RATE   = 2'd1,
        REG_TIME_H = 2'd2,
        REG_TIME_L = 2'd3
    } ftc_reg_e;

    // Bit position of the capture command inside the command word
    localparam int CMD_CAPTURE_BIT = 0;
endpackage

// File: rtl/ftc_phase_accum.sv
// Module: phase accumulator. Adds the rate word each cycle, keeps the
// remainder modulo 2^ACC_W and exposes the carry out combinationally.
// Assumes clear has priority over accumulation.
module ftc_phase_accum #(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] rate,
    input  logic             clear,
    output logic [ACC_W-1:0] acc_q,
    output logic             carry
);
    localparam int SUM_W = ACC_W + 1;

    logic [SUM_W-1:0] sum;

    // Widened sum so the carry out is visible
    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, rate};
        carry = sum[ACC_W];
    end

    // Hold the residual phase, or clear it on a time load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
        end else begin
            acc_q <= sum[ACC_W-1:0];
        end
    end
endmodule

// File: rtl/ftc_time_counter.sv
// Module: the live time count. Steps by one on inc, takes load_val on load.
// Assumes load wins over inc in the same cycle.
module ftc_time_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_q
);
    // Count register: load, step, or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (inc) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/ftc_host_regs.sv
// Module: host register port. Holds the rate word, the capture command
// and captured time, and stages both halves of a time load.
// Assumes a single-cycle write strobe and combinational read data.
module ftc_host_regs
    import ftc_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int          ACC_W    = 32,
    parameter logic [31:0] RATE_RST = 32'h8000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic                host_wr,
    input  logic [DATA_W-1:0]   host_wdata,
    output logic [DATA_W-1:0]   host_rdata,
    input  logic [2*DATA_W-1:0] time_now,
    output logic [ACC_W-1:0]    rate_q,
    output logic                load_fire,
    output logic [2*DATA_W-1:0] load_val,
    output logic [2*DATA_W-1:0] snap_q,
    output logic                cap_bit_q
);
    localparam int CNT_W = 2 * DATA_W;

    logic              wr_cmd, wr_rate, wr_hi, wr_lo, cap_req;
    logic [DATA_W-1:0] stage_hi_q, stage_lo_q;
    logic              pend_hi_q, pend_lo_q;

    // Write decode
    always_comb begin
        wr_cmd  = host_wr && (host_addr == REG_CMD);
        wr_rate = host_wr && (host_addr == REG_RATE);
        wr_hi   = host_wr && (host_addr == REG_TIME_H);
        wr_lo   = host_wr && (host_addr == REG_TIME_L);
        cap_req = wr_cmd && host_wdata[CMD_CAPTURE_BIT];
    end

    // Rate word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= ACC_W'(RATE_RST);
        end else if (wr_rate) begin
            rate_q <= ACC_W'(host_wdata);
        end
    end

    // Capture command pulse and frozen copy of the count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_bit_q <= 1'b0;
            snap_q    <= '0;
        end else begin
            cap_bit_q <= cap_req;
            if (cap_req) begin
                snap_q <= time_now;
            end
        end
    end

    // Staged load halves and their pending flags; a new write re-arms
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_hi_q <= '0;
            stage_lo_q <= '0;
            pend_hi_q  <= 1'b0;
            pend_lo_q  <= 1'b0;
        end else begin
            if (load_fire) begin
                pend_hi_q <= 1'b0;
                pend_lo_q <= 1'b0;
            end
            if (wr_hi) begin
                stage_hi_q <= host_wdata;
                pend_hi_q  <= 1'b1;
            end
            if (wr_lo) begin
                stage_lo_q <= host_wdata;
                pend_lo_q  <= 1'b1;
            end
        end
    end

    // Load is requested once both halves are staged
    always_comb begin
        load_fire = pend_hi_q && pend_lo_q;
        load_val  = {stage_hi_q, stage_lo_q};
    end

    // Read mux
    always_comb begin
        case (host_addr)
            REG_CMD:    host_rdata = DATA_W'(cap_bit_q);
            REG_RATE:   host_rdata = DATA_W'(rate_q);
            REG_TIME_H: host_rdata = snap_q[CNT_W-1:DATA_W];
            default:    host_rdata = snap_q[DATA_W-1:0];
        endcase
    end
endmodule

// File: rtl/frac_time_clock.sv
// Module: top of the fractional-rate timestamp clock. Wires the host port,
// phase accumulator and time count together in one clock domain.
// Assumes the reference clock drives clk and the host shares it.
module frac_time_clock
    import ftc_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int          ACC_W    = 32,
    parameter logic [31:0] RATE_RST = 32'h8000_0000
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          host_addr,
    input  logic                host_wr,
    input  logic [31:0]         host_wdata,
    output logic [31:0]         host_rdata,
    output logic [63:0]         time_now
);
    localparam int CNT_W = 2 * DATA_W;

    logic [ACC_W-1:0] rate_q, acc_q;
    logic             carry, load_fire, cap_bit_q;
    logic [CNT_W-1:0] load_val, snap_q, cnt_q;

    ftc_host_regs #(
        .DATA_W   (DATA_W),
        .ACC_W    (ACC_W),
        .RATE_RST (RATE_RST)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .time_now   (cnt_q),
        .rate_q     (rate_q),
        .load_fire  (load_fire),
        .load_val   (load_val),
        .snap_q     (snap_q),
        .cap_bit_q  (cap_bit_q)
    );

    ftc_phase_accum #(
        .ACC_W (ACC_W)
    ) u_accum (
        .clk   (clk),
        .rst_n (rst_n),
        .rate  (rate_q),
        .clear (load_fire),
        .acc_q (acc_q),
        .carry (carry)
    );

    ftc_time_counter #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (carry),
        .load     (load_fire),
        .load_val (load_val),
        .cnt_q    (cnt_q)
    );

    // Live count out
    assign time_now = cnt_q;
endmodule

// File: rtl/frac_time_clock_chk.sv
// Module: assertion checker for frac_time_clock, bound to every instance.
// Assumes the internal names acc_q, carry, load_fire, load_val, snap_q, cap_bit_q.
module frac_time_clock_chk #(
    parameter int DATA_W = 32,
    parameter int ACC_W  = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          host_addr,
    input logic                host_wr,
    input logic [DATA_W-1:0]   host_wdata,
    input logic [2*DATA_W-1:0] cnt,
    input logic [ACC_W-1:0]    acc,
    input logic                carry,
    input logic                load_fire,
    input logic [2*DATA_W-1:0] load_val,
    input logic [2*DATA_W-1:0] snap,
    input logic                cap_bit
);
    logic cap_wr;
    // Capture command seen at the port
    assign cap_wr = host_wr && (host_addr == 2'd0) && host_wdata[0];

    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !load_fire |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    a_r2_carry_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !load_fire) |=> cnt == $past(cnt) + 1'b1);

    a_r8_load_applies: assert property (@(posedge clk) disable iff (!rst_n)
        load_fire |=> (cnt == $past(load_val) && acc == '0));

    a_r5_snap_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_wr |=> $stable(snap));

    a_r6_cmd_selfclear: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_bit && !cap_wr) |=> !cap_bit);
endmodule

bind frac_time_clock frac_time_clock_chk #(
    .DATA_W (DATA_W),
    .ACC_W  (ACC_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .cnt        (time_now),
    .acc        (acc_q),
    .carry      (carry),
    .load_fire  (load_fire),
    .load_val   (load_val),
    .snap       (snap_q),
    .cap_bit    (cap_bit_q)
);

// File: tb/frac_time_clock_tb.sv
module frac_time_clock_tb;
    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_addr = 2'd0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [63:0] time_now;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    frac_time_clock u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .time_now   (time_now)
    );

    always #HALF clk = ~clk;

    // Behavioural reference model
    logic [63:0] m_cnt, m_snap;
    logic [31:0] m_acc, m_rate, m_hi, m_lo;
    logic        m_phi, m_plo, m_cmd;

    always @(posedge clk) begin
        logic [32:0] s;
        if (!rst_n) begin
            m_cnt = 0; m_snap = 0; m_acc = 0; m_rate = 32'h8000_0000;
            m_hi = 0; m_lo = 0; m_phi = 0; m_plo = 0; m_cmd = 0;
        end else begin
            s = {1'b0, m_acc} + {1'b0, m_rate};
            m_cmd = 0;
            if (host_wr && host_addr == 2'd0 && host_wdata[0]) begin
                m_snap = m_cnt; m_cmd = 1;
            end
            if (m_phi && m_plo) begin
                m_cnt = {m_hi, m_lo}; m_acc = 0; m_phi = 0; m_plo = 0;
            end else begin
                m_acc = s[31:0];
                if (s[32]) m_cnt = m_cnt + 1;
            end
            if (host_wr && host_addr == 2'd1) m_rate = host_wdata;
            if (host_wr && host_addr == 2'd2) begin m_hi = host_wdata; m_phi = 1; end
            if (host_wr && host_addr == 2'd3) begin m_lo = host_wdata; m_plo = 1; end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Every-clock comparison against the model
    always @(negedge clk) begin
        logic [31:0] exp_rd;
        #2;
        if (rst_n && !done) begin
            check("R2 time_now", time_now, m_cnt);
            case (host_addr)
                2'd0: exp_rd = {31'd0, m_cmd};
                2'd1: exp_rd = m_rate;
                2'd2: exp_rd = m_snap[63:32];
                default: exp_rd = m_snap[31:0];
            endcase
            check(host_addr == 2'd0 ? "R6 cmd read" :
                  host_addr == 2'd1 ? "R9 rate read" : "R5 capture read",
                  {32'd0, host_rdata}, {32'd0, exp_rd});
        end
    end

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #3 d = host_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        #(HALF * 2 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] d, h, l;
        logic [63:0] t0, t1;
        idle(5);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd1, d); check("R1 rate reset", {32'd0, d}, 64'h8000_0000);
        rd(2'd2, d); check("R1 capture hi reset", {32'd0, d}, 64'd0);
        rd(2'd3, d); check("R1 capture lo reset", {32'd0, d}, 64'd0);
        rd(2'd0, d); check("R1 cmd reset", {32'd0, d}, 64'd0);
        idle(20);

        // R6 command pulse and self-clear
        wr(2'd0, 32'h1);
        host_addr = 2'd0; #3 check("R6 cmd pulse", {32'd0, host_rdata}, 64'd1);
        rd(2'd0, d); check("R6 cmd cleared", {32'd0, d}, 64'd0);

        // R9 command write without the capture bit
        t0 = m_snap;
        wr(2'd0, 32'hFFFF_FFFE);
        idle(3);
        rd(2'd2, h); rd(2'd3, l);
        check("R9 no capture", {h, l}, t0);

        // R7/R8 load low then high with zero rate: exact readback
        wr(2'd1, 32'h0);
        wr(2'd3, 32'hFFFF_FFF0);
        wr(2'd2, 32'h0000_0001);
        idle(3);
        check("R7 load either order", time_now, 64'h1_FFFF_FFF0);

        // R7 single half leaves count alone
        wr(2'd2, 32'h55);
        idle(5);
        check("R7 single half", time_now, 64'h1_FFFF_FFF0);
        wr(2'd3, 32'h66);
        idle(1);
        check("R7 second half loads", time_now, 64'h55_0000_0066);

        // R8 carry dropped in the load cycle, accumulator cleared
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd3, 32'hFFFF_FFFE);
        wr(2'd2, 32'h0);
        @(negedge clk); #3;
        check("R8 load exact", time_now, 64'h0_FFFF_FFFE);
        @(negedge clk); #3;
        check("R8 acc cleared", time_now, 64'h0_FFFF_FFFE);
        @(negedge clk); #3;
        check("R2 first carry", time_now, 64'h0_FFFF_FFFF);

        // R5 capture across low-word rollover
        idle(6);
        wr(2'd0, 32'h1);
        t0 = m_snap;
        idle(4);
        rd(2'd3, l); rd(2'd2, h);
        check("R5 coherent capture", {h, l}, t0);
        check("R5 past rollover", {32'd0, h}, 64'd1);

        // R3 rates measured from a cleared accumulator
        wr(2'd1, 32'hC000_0000);
        wr(2'd2, 32'h0); wr(2'd3, 32'h0);
        @(negedge clk); #3 t0 = time_now;
        idle(400); #3 t1 = time_now;
        check("R3 rate C0000000h", t1 - t0, 64'd300);
        wr(2'd1, 32'h8000_0000);
        wr(2'd2, 32'h0); wr(2'd3, 32'h0);
        @(negedge clk); #3 t0 = time_now;
        idle(400); #3 t1 = time_now;
        check("R3 rate 80000000h", t1 - t0, 64'd200);

        // R4 rate changes mid-run, checked by the model each clock
        wr(2'd1, 32'hE666_6666); idle(37);
        wr(2'd1, 32'h0000_0001); idle(11);
        wr(2'd1, 32'hA8F5_C28F); idle(29);
        rd(2'd1, d); check("R4 rate readback", {32'd0, d}, 64'hA8F5_C28F);

        // Random register traffic
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            host_addr  = 2'($urandom_range(0, 3));
            host_wr    = ($urandom_range(0, 3) == 0);
            host_wdata = $urandom;
        end
        @(negedge clk); host_wr = 1'b0;
        idle(4);
        finish_run();
    end
endmodule